// File: doc/BRIEF.md
# Video Clamp Window Generator

This block produces two clamp strobes for a video input path. The horizontal strobe is placed within each line by counting a 480 ns time base from the rising edge of horizontal sync. The vertical strobe is placed within each field by counting lines from the rising edge of vertical sync. Software chooses the begin and end positions of both windows through a small register write port and can read them back. The block also reports whether the current field is odd or even, as seen by an external field detector.

A window covers the positions from its begin value up to, but not including, its end value. If the end value is below the begin value, the window wraps: it covers everything from the begin value to the end of the count and from zero up to the end value, which places it over the sync interval. Software writes land in shadow registers. The horizontal settings are copied into use at the next horizontal sync rise, and the vertical settings at the next vertical sync rise, so a window already in progress is never cut short. Sync inputs are asynchronous and pass through a two-flop synchronizer before edge detection.

Top module: `clamp_window_gen`

## Requirements
- R1: After reset every register reads 0, both clamp strobes are low and the field flag is 0.
- R2: Register addresses are 0 horizontal begin (8 bits), 1 horizontal end (8 bits), 2 vertical begin bits [7:0], 3 vertical begin bits [9:8] in data bits [1:0], 4 vertical end bits [7:0], 5 vertical end bits [9:8] in data bits [1:0], 6 field flag in bit 0. Written values read back on `rd_data` in the same cycle that `rd_addr` is set. Unused data bits and address 7 read 0.
- R3: The horizontal position is 0 in the third clock cycle after `hsync_in` is first sampled high. After that it rises by one on each clock edge where `tick_en` is high, holds when `tick_en` is low, and stops at 255.
- R4: When horizontal end is above horizontal begin, `hclamp_o` is high exactly when begin <= position < end.
- R5: When horizontal end is below horizontal begin, `hclamp_o` is high when position >= begin or position < end.
- R6: When begin equals end, the strobe of that window stays low.
- R7: The line count is 0 from the third cycle after `vsync_in` is first sampled high. It rises by one at each horizontal sync rise, with the same three-cycle latency, and stops at 1023.
- R8: `vclamp_o` follows the same normal and wrapped window rules on the 10-bit line count, with begin and end each built from their two registers.
- R9: A write changes only the shadow value. The horizontal window uses it from the next horizontal sync rise, and the vertical window from the next vertical sync rise.
- R10: The field flag (`field_odd_o`, and address 6 bit 0) takes the synchronized `field_odd_in` level (1 odd, 0 even) at each vertical sync rise and holds it otherwise. Writes to address 6 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle pulse every 480 ns, advances the horizontal position |
| hsync_in | input | 1 | Horizontal sync, asynchronous, active high |
| vsync_in | input | 1 | Vertical sync, asynchronous, active high |
| field_odd_in | input | 1 | Field detector output, 1 for odd field |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Register read data (shadow values and field flag) |
| hclamp_o | output | 1 | Horizontal clamp strobe |
| vclamp_o | output | 1 | Vertical clamp strobe |
| field_odd_o | output | 1 | Odd-field flag |

## Verification
The horizontal window is tried with a normal window, a wrapped window, equal limits, a window near the top of the count, and a stalled time base. Together these separate a correct begin/end comparison from off-by-one and inverted-wrap errors, and a saturating counter from one that rolls over. The vertical window is tried with a short normal frame, a wrapped frame whose limits need the upper register bits, and a frame longer than 1023 lines with a wrapped window at the top of the count, which exposes a lost high bit or a rolling line counter. One sequence rewrites the horizontal registers in the middle of a line and checks that the running window keeps its old shape until the next sync rise. Another changes the field input with and without a vertical sync, which separates sampling at the field start from following the input directly.

// File: rtl/cwg_pkg.sv
package cwg_pkg;

  localparam int CWG_DATA_W      = 8;
  localparam int CWG_ADDR_W      = 3;
  localparam int CWG_H_W         = 8;
  localparam int CWG_V_W         = 10;
  localparam int CWG_SYNC_STAGES = 2;

  // Register addresses of the write/read port.
  typedef enum logic [CWG_ADDR_W-1:0] {
    CWG_A_H_BEG    = 3'd0,
    CWG_A_H_END    = 3'd1,
    CWG_A_V_BEG_LO = 3'd2,
    CWG_A_V_BEG_HI = 3'd3,
    CWG_A_V_END_LO = 3'd4,
    CWG_A_V_END_HI = 3'd5,
    CWG_A_FIELD    = 3'd6
  } cwg_addr_e;

  // Window test: half-open [beg, fin); wraps when fin < beg; empty when equal.
  function automatic logic cwg_in_window(input logic [15:0] cnt,
                                         input logic [15:0] beg,
                                         input logic [15:0] fin);
    logic hit;
    if (fin < beg) hit = (cnt >= beg) || (cnt < fin);
    else           hit = (cnt >= beg) && (cnt < fin);
    return hit;
  endfunction

endpackage

// File: rtl/cwg_sync.sv
// Multi-stage synchronizer, one independent chain per bit.
module cwg_sync #(
  parameter int N      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] level_o
);

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    always_comb begin
      chain_d = {chain_q[STAGES-2:0], async_i[i]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= chain_d;
    end

    assign level_o[i] = chain_q[STAGES-1];
  end

endmodule

// File: rtl/cwg_sync_edge.sv
// Synchronizer followed by a one-cycle rising-edge pulse per bit.
module cwg_sync_edge #(
  parameter int N      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] rise_o
);

  logic [N-1:0] level;
  logic [N-1:0] prev_q;
  logic [N-1:0] prev_d;

  cwg_sync #(.N(N), .STAGES(STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (async_i),
    .level_o (level)
  );

  always_comb begin
    prev_d = level;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_d;
  end

  assign rise_o = level & ~prev_q;

endmodule

// File: rtl/cwg_regfile.sv
// Shadow registers written by software, active copies loaded at sync rises,
// and the field flag sampled at the field start.
module cwg_regfile
  import cwg_pkg::*;
#(
  parameter int DATA_W = CWG_DATA_W,
  parameter int ADDR_W = CWG_ADDR_W,
  parameter int H_W    = CWG_H_W,
  parameter int V_W    = CWG_V_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              h_load_i,
  input  logic              v_load_i,
  input  logic              field_lvl_i,
  output logic [H_W-1:0]    h_beg_o,
  output logic [H_W-1:0]    h_end_o,
  output logic [V_W-1:0]    v_beg_o,
  output logic [V_W-1:0]    v_end_o,
  output logic              field_o
);

  localparam int V_HI_W = V_W - DATA_W;

  logic [H_W-1:0] h_beg_sh_q, h_beg_sh_d, h_end_sh_q, h_end_sh_d;
  logic [V_W-1:0] v_beg_sh_q, v_beg_sh_d, v_end_sh_q, v_end_sh_d;
  logic [H_W-1:0] h_beg_act_q, h_beg_act_d, h_end_act_q, h_end_act_d;
  logic [V_W-1:0] v_beg_act_q, v_beg_act_d, v_end_act_q, v_end_act_d;
  logic           field_q, field_d;

  // Next-state: software writes to shadows
  always_comb begin
    h_beg_sh_d = h_beg_sh_q;
    h_end_sh_d = h_end_sh_q;
    v_beg_sh_d = v_beg_sh_q;
    v_end_sh_d = v_end_sh_q;
    if (wr_en) begin
      case (wr_addr)
        ADDR_W'(CWG_A_H_BEG):    h_beg_sh_d = wr_data[H_W-1:0];
        ADDR_W'(CWG_A_H_END):    h_end_sh_d = wr_data[H_W-1:0];
        ADDR_W'(CWG_A_V_BEG_LO): v_beg_sh_d = {v_beg_sh_q[V_W-1:DATA_W], wr_data};
        ADDR_W'(CWG_A_V_BEG_HI): v_beg_sh_d = {wr_data[V_HI_W-1:0], v_beg_sh_q[DATA_W-1:0]};
        ADDR_W'(CWG_A_V_END_LO): v_end_sh_d = {v_end_sh_q[V_W-1:DATA_W], wr_data};
        ADDR_W'(CWG_A_V_END_HI): v_end_sh_d = {wr_data[V_HI_W-1:0], v_end_sh_q[DATA_W-1:0]};
        default: ;
      endcase
    end
  end

  // Next-state: active copies change only at the matching sync rise
  always_comb begin
    h_beg_act_d = h_load_i ? h_beg_sh_q : h_beg_act_q;
    h_end_act_d = h_load_i ? h_end_sh_q : h_end_act_q;
    v_beg_act_d = v_load_i ? v_beg_sh_q : v_beg_act_q;
    v_end_act_d = v_load_i ? v_end_sh_q : v_end_act_q;
    field_d     = v_load_i ? field_lvl_i : field_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_beg_sh_q  <= '0;
      h_end_sh_q  <= '0;
      v_beg_sh_q  <= '0;
      v_end_sh_q  <= '0;
      h_beg_act_q <= '0;
      h_end_act_q <= '0;
      v_beg_act_q <= '0;
      v_end_act_q <= '0;
      field_q     <= 1'b0;
    end else begin
      h_beg_sh_q  <= h_beg_sh_d;
      h_end_sh_q  <= h_end_sh_d;
      v_beg_sh_q  <= v_beg_sh_d;
      v_end_sh_q  <= v_end_sh_d;
      h_beg_act_q <= h_beg_act_d;
      h_end_act_q <= h_end_act_d;
      v_beg_act_q <= v_beg_act_d;
      v_end_act_q <= v_end_act_d;
      field_q     <= field_d;
    end
  end

  // Readback of shadows and flag
  always_comb begin
    case (rd_addr)
      ADDR_W'(CWG_A_H_BEG):    rd_data = DATA_W'(h_beg_sh_q);
      ADDR_W'(CWG_A_H_END):    rd_data = DATA_W'(h_end_sh_q);
      ADDR_W'(CWG_A_V_BEG_LO): rd_data = v_beg_sh_q[DATA_W-1:0];
      ADDR_W'(CWG_A_V_BEG_HI): rd_data = DATA_W'(v_beg_sh_q[V_W-1:DATA_W]);
      ADDR_W'(CWG_A_V_END_LO): rd_data = v_end_sh_q[DATA_W-1:0];
      ADDR_W'(CWG_A_V_END_HI): rd_data = DATA_W'(v_end_sh_q[V_W-1:DATA_W]);
      ADDR_W'(CWG_A_FIELD):    rd_data = DATA_W'(field_q);
      default:                 rd_data = '0;
    endcase
  end

  assign h_beg_o = h_beg_act_q;
  assign h_end_o = h_end_act_q;
  assign v_beg_o = v_beg_act_q;
  assign v_end_o = v_end_act_q;
  assign field_o = field_q;

endmodule

// File: rtl/cwg_pos_counter.sv
// Position counter: cleared by a sync rise, advanced by an enable, saturating.
module cwg_pos_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear_i,
  input  logic         advance_i,
  output logic [W-1:0] count_o
);

  localparam logic [W-1:0] CNT_MAX = '1;

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clear_i)                          cnt_d = '0;
    else if (advance_i && cnt_q != CNT_MAX) cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;

endmodule

// File: rtl/clamp_window_gen.sv
module clamp_window_gen
  import cwg_pkg::*;
#(
  parameter int DATA_W      = CWG_DATA_W,
  parameter int ADDR_W      = CWG_ADDR_W,
  parameter int H_W         = CWG_H_W,
  parameter int V_W         = CWG_V_W,
  parameter int SYNC_STAGES = CWG_SYNC_STAGES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              hsync_in,
  input  logic              vsync_in,
  input  logic              field_odd_in,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              hclamp_o,
  output logic              vclamp_o,
  output logic              field_odd_o
);

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q, rst_pipe_d;
  logic       rst_core_n;

  always_comb begin
    rst_pipe_d = {rst_pipe_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= rst_pipe_d;
  end

  assign rst_core_n = rst_pipe_q[1];

  // Sync edge detection (bit 0 horizontal, bit 1 vertical)
  logic [1:0] sync_rise;
  logic       h_rise, v_rise;
  logic       field_lvl;

  cwg_sync_edge #(.N(2), .STAGES(SYNC_STAGES)) u_edge (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .async_i ({vsync_in, hsync_in}),
    .rise_o  (sync_rise)
  );

  assign h_rise = sync_rise[0];
  assign v_rise = sync_rise[1];

  cwg_sync #(.N(1), .STAGES(SYNC_STAGES)) u_field_sync (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .async_i (field_odd_in),
    .level_o (field_lvl)
  );

  // Registers
  logic [H_W-1:0] h_beg_act, h_end_act;
  logic [V_W-1:0] v_beg_act, v_end_act;

  cwg_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .H_W(H_W), .V_W(V_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .rd_addr     (rd_addr),
    .rd_data     (rd_data),
    .h_load_i    (h_rise),
    .v_load_i    (v_rise),
    .field_lvl_i (field_lvl),
    .h_beg_o     (h_beg_act),
    .h_end_o     (h_end_act),
    .v_beg_o     (v_beg_act),
    .v_end_o     (v_end_act),
    .field_o     (field_odd_o)
  );

  // Position counters
  logic [H_W-1:0] h_cnt;
  logic [V_W-1:0] v_cnt;

  cwg_pos_counter #(.W(H_W)) u_hcnt (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .clear_i   (h_rise),
    .advance_i (tick_en),
    .count_o   (h_cnt)
  );

  cwg_pos_counter #(.W(V_W)) u_vcnt (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .clear_i   (v_rise),
    .advance_i (h_rise),
    .count_o   (v_cnt)
  );

  // Window decode from registered state only
  assign hclamp_o = cwg_in_window(16'(h_cnt), 16'(h_beg_act), 16'(h_end_act));
  assign vclamp_o = cwg_in_window(16'(v_cnt), 16'(v_beg_act), 16'(v_end_act));

endmodule

// File: rtl/cwg_checker.sv
module cwg_checker #(
  parameter int H_W = 8,
  parameter int V_W = 10
) (
  input logic           clk,
  input logic           rst_core_n,
  input logic           h_rise,
  input logic           v_rise,
  input logic           tick_en,
  input logic [H_W-1:0] h_cnt,
  input logic [V_W-1:0] v_cnt,
  input logic [H_W-1:0] h_beg_act,
  input logic [H_W-1:0] h_end_act,
  input logic [V_W-1:0] v_beg_act,
  input logic [V_W-1:0] v_end_act,
  input logic           hclamp_o,
  input logic           vclamp_o,
  input logic           field_odd_o
);

  // R3
  h_clear_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    h_rise |=> (h_cnt == '0));

  // R3
  h_sat_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!h_rise && h_cnt == '1) |=> (h_cnt == '1));

  // R3
  h_idle_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!h_rise && !tick_en) |=> $stable(h_cnt));

  // R7
  v_clear_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    v_rise |=> (v_cnt == '0));

  // R7
  v_sat_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!v_rise && v_cnt == '1) |=> (v_cnt == '1));

  // R6
  h_empty_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (h_beg_act == h_end_act) |-> !hclamp_o);

  // R6
  v_empty_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (v_beg_act == v_end_act) |-> !vclamp_o);

  // R9
  h_hold_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    !h_rise |=> ($stable(h_beg_act) && $stable(h_end_act)));

  // R9
  v_hold_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    !v_rise |=> ($stable(v_beg_act) && $stable(v_end_act)));

  // R10
  field_hold_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    !v_rise |=> $stable(field_odd_o));

endmodule

bind clamp_window_gen cwg_checker #(.H_W(H_W), .V_W(V_W)) u_chk (
  .clk         (clk),
  .rst_core_n  (rst_core_n),
  .h_rise      (h_rise),
  .v_rise      (v_rise),
  .tick_en     (tick_en),
  .h_cnt       (h_cnt),
  .v_cnt       (v_cnt),
  .h_beg_act   (h_beg_act),
  .h_end_act   (h_end_act),
  .v_beg_act   (v_beg_act),
  .v_end_act   (v_end_act),
  .hclamp_o    (hclamp_o),
  .vclamp_o    (vclamp_o),
  .field_odd_o (field_odd_o)
);

// File: tb/tb_clamp_window_gen.sv
`timescale 1ns/1ps
module tb_clamp_window_gen;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b1;
  logic       hsync_in = 1'b0;
  logic       vsync_in = 1'b0;
  logic       field_odd_in = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       hclamp_o, vclamp_o, field_odd_o;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  clamp_window_gen dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .hsync_in(hsync_in),
    .vsync_in(vsync_in), .field_odd_in(field_odd_in), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .hclamp_o(hclamp_o), .vclamp_o(vclamp_o), .field_odd_o(field_odd_o)
  );

  // Scoreboard
  typedef struct {
    int    when;
    bit    is_v;
    bit    exp;
    string tag;
  } sb_item_t;

  sb_item_t sb_q[$];
  sb_item_t cur;
  logic     act;

  function automatic bit win(int c, int b, int e);
    if (e < b) return (c >= b) || (c < e);
    return (c >= b) && (c < e);
  endfunction

  always @(negedge clk) begin
    while (sb_q.size() > 0 && sb_q[0].when == cyc) begin
      cur = sb_q.pop_front();
      act = cur.is_v ? vclamp_o : hclamp_o;
      checks++;
      if (act !== cur.exp) begin
        failures++;
        $display("FAIL %s %s cycle=%0d actual=%0b expected=%0b",
                 cur.tag, cur.is_v ? "vclamp" : "hclamp", cyc, act, cur.exp);
      end
    end
  end

  task automatic chk(input string tag, input logic [7:0] a, input logic [7:0] e);
    checks++;
    if (a !== e) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, a, e);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [2:0] a, input logic [7:0] e);
    @(negedge clk);
    rd_addr = a;
    #1;
    chk(tag, rd_data, e);
  endtask

  task automatic sb_drain();
    while (sb_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // Raise hsync and queue the expected horizontal strobe for len cycles.
  task automatic h_start(input int hb, input int he, input int len,
                         input bit ticking, input string tag);
    sb_item_t it;
    @(negedge clk);
    hsync_in = 1'b1;
    for (int j = 0; j < len; j++) begin
      int c;
      c = ticking ? ((j > 255) ? 255 : j) : 0;
      it.when = cyc + 3 + j; it.is_v = 1'b0; it.exp = win(c, hb, he); it.tag = tag;
      sb_q.push_back(it);
    end
    repeat (3) @(negedge clk);
    hsync_in = 1'b0;
  endtask

  task automatic h_line(input int hb, input int he, input int len,
                        input bit ticking, input string tag);
    wr(3'd0, 8'(hb));
    wr(3'd1, 8'(he));
    h_start(hb, he, len, ticking, tag);
    sb_drain();
  endtask

  // One field: vsync rise, then lines hsync rises four cycles apart.
  task automatic v_frame(input int vb, input int ve, input int lines, input string tag);
    sb_item_t it;
    int m0;
    wr(3'd2, 8'(vb & 255));
    wr(3'd3, 8'(vb >> 8));
    wr(3'd4, 8'(ve & 255));
    wr(3'd5, 8'(ve >> 8));
    @(negedge clk);
    m0 = cyc;
    for (int s = m0 + 3; s <= m0 + 4 * lines + 7; s++) begin
      int l;
      l = (s - m0 - 3) / 4;
      if (l > lines) l = lines;
      if (l > 1023) l = 1023;
      it.when = s; it.is_v = 1'b1; it.exp = win(l, vb, ve); it.tag = tag;
      sb_q.push_back(it);
    end
    vsync_in = 1'b1;
    for (int d = 1; d <= 4 * lines + 8; d++) begin
      @(negedge clk);
      vsync_in = (d < 2);
      hsync_in = (d >= 4) && ((d % 4) < 2) && ((d / 4) <= lines);
    end
    hsync_in = 1'b0;
    sb_drain();
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: strobes low while in reset
    chk("R1 hclamp in reset", {7'd0, hclamp_o}, 8'd0);
    chk("R1 vclamp in reset", {7'd0, vclamp_o}, 8'd0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    for (int a = 0; a < 8; a++) rd("R1 register reset value", 3'(a), 8'd0);
    chk("R1 field output", {7'd0, field_odd_o}, 8'd0);

    // R2: readback and field widths
    wr(3'd0, 8'h3C); rd("R2 hbeg readback", 3'd0, 8'h3C);
    wr(3'd1, 8'hC3); rd("R2 hend readback", 3'd1, 8'hC3);
    wr(3'd2, 8'hA5); rd("R2 vbeg lo readback", 3'd2, 8'hA5);
    wr(3'd3, 8'hFF); rd("R2 vbeg hi two bits", 3'd3, 8'h03);
    wr(3'd5, 8'hFE); rd("R2 vend hi two bits", 3'd5, 8'h02);
    wr(3'd7, 8'hFF); rd("R2 address 7 reads zero", 3'd7, 8'h00);

    // Horizontal windows
    h_line(10, 20, 40, 1'b1, "R4 normal window");
    h_line(200, 5, 300, 1'b1, "R5 wrapped window with saturation");
    h_line(7, 7, 40, 1'b1, "R6 equal limits");
    h_line(250, 255, 300, 1'b1, "R3 saturation at 255");
    tick_en = 1'b0;
    h_line(0, 1, 40, 1'b0, "R3 no advance without tick");
    tick_en = 1'b1;

    // R9: rewrite mid-line; running line keeps the old window
    wr(3'd0, 8'd10); wr(3'd1, 8'd20);
    h_start(10, 20, 60, 1'b1, "R9 old window kept mid-line");
    wr(3'd0, 8'd30); wr(3'd1, 8'd40);
    sb_drain();
    h_start(30, 40, 60, 1'b1, "R9 new window at next sync");
    sb_drain();

    // R10: field input alone does not move the flag
    field_odd_in = 1'b1;
    h_line(3, 4, 10, 1'b1, "R4 short line");
    rd("R10 flag before vsync", 3'd6, 8'h00);
    chk("R10 flag output before vsync", {7'd0, field_odd_o}, 8'd0);

    // Vertical windows
    v_frame(3, 6, 12, "R8 normal vertical window");
    rd("R10 flag odd after vsync", 3'd6, 8'h01);
    chk("R10 flag output odd", {7'd0, field_odd_o}, 8'd1);
    wr(3'd6, 8'h00);
    rd("R10 write to flag ignored", 3'd6, 8'h01);
    v_frame(5, 5, 12, "R6 equal vertical limits");
    field_odd_in = 1'b0;
    h_line(1, 2, 10, 1'b1, "R4 line without vsync");
    chk("R10 flag held without vsync", {7'd0, field_odd_o}, 8'd1);
    v_frame(259, 257, 262, "R8 wrapped ten-bit window");
    chk("R10 flag even after vsync", {7'd0, field_odd_o}, 8'd0);
    v_frame(1022, 0, 1030, "R7 line count saturates at 1023");

    finish_run();
  end

endmodule